// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous requester and a 32K x 8 asynchronous static RAM that has one shared data bus. The requester presents an address, write data and a read/write flag. The request is taken on a clock edge where the block signals that it is ready. The block then drives the RAM's active-low chip-select, output-enable and write-strobe lines. It also controls the enable of its own drivers onto the shared bus. For a read, it returns the captured byte together with a one-cycle valid pulse.

The RAM has no clock, so every timing limit is met by counting cycles of the system clock. Each limit (access time, output-enable access, minimum cycle time, write pulse width, data-to-strobe overlap, output float time) is given in picoseconds as a parameter. At elaboration, each limit is divided by the clock period and rounded up, with a floor of one cycle. At the default 5 ns clock the counts are: read access 3 cycles, bus turnaround 2 cycles, write pulse 2 cycles.

Writes are timed by the write strobe. Output-enable stays high for the whole write. The block's drivers switch on only after a turnaround wait. Address and data are held for one cycle after the write strobe rises. The block returns to an idle cycle between any two accesses. In that idle cycle chip-select is high, which puts the RAM in standby.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no request, chip-select, output-enable and write-strobe are all high (1), the bus drivers are off, `req_ready` is 1 and `rsp_valid` is 0.
- R2: After a read is accepted, chip-select and output-enable are low and write-strobe is high for exactly ACC cycles, with the bus drivers off. ACC is the largest of ceil(12 ns/period), ceil(7 ns/period) and ceil(12 ns/period), which is 3 at 5 ns. `mem_addr` equals the request address throughout.
- R3: In the cycle after the last access cycle of a read, `rsp_valid` is 1 for one cycle, `rsp_rdata` holds the byte the RAM drove during that last access cycle, output-enable is high and chip-select is still low.
- R4: After a write is accepted, there are TURN = max(1, ceil(6 ns/period)) cycles (2 at 5 ns) in which chip-select is low, output-enable and write-strobe are high, and the bus drivers are off.
- R5: The write-strobe pulse that follows lasts WP = max(1, ceil(8 ns/period), ceil(8 ns/period)) cycles (2 at 5 ns). During it the bus drivers are on and `mem_dq_out` and `mem_addr` carry the request's data and address.
- R6: For one cycle after write-strobe rises, chip-select stays low and the drivers stay on, with address and data unchanged. The block then goes idle.
- R7: The bus drivers are never on while output-enable is low, and write-strobe and output-enable are never low together.
- R8: A request is accepted only when `req_ready` is 1, which is only in idle. While the block is busy, changes to `req_valid`, `req_write`, `req_addr` and `req_wdata` have no effect on the strobes, address or data.
- R9: Every idle cycle has chip-select high. At least one idle cycle separates any two accesses, including a read followed by a write and a write followed by a read.
- R10: A write-strobe pulse is never shorter than WP cycles, and the drivers are never switched on fewer than TURN cycles after output-enable last went high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | High in idle; request taken when both valid and ready |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Captured read byte |
| mem_addr | output | 15 | RAM address lines |
| mem_ce_n | output | 1 | RAM chip-select, active low |
| mem_oe_n | output | 1 | RAM output-enable, active low |
| mem_we_n | output | 1 | RAM write-strobe, active low |
| mem_dq_out | output | 8 | Byte driven onto the shared bus |
| mem_dq_oe | output | 1 | Enable of the block's bus drivers |
| mem_dq_in | input | 8 | Byte seen on the shared bus |

## Verification
A wrong state or a miscounted timer shows at the strobe pins in the very next cycle. Examples are a strobe pulse one cycle short or long, a missing turnaround or a skipped hold cycle. The reference model compares every strobe, the driver enable and `req_ready` on every clock, so such a fault is reported in the cycle it first appears. A wrong capture point or a lost address register shows only when `rsp_valid` pulses: the returned byte differs from what the model stored. Writes and reads therefore use distinct addresses and data, including the first and last words.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and elaboration-time helpers for the SRAM access sequencer.
// Assumes all timing limits and the clock period are given in picoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_ACK   = 3'd2,
        ST_WR_TURN  = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
        logic rsp;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0, rsp: 1'b0};

    // Whole cycles covering a limit, never fewer than one.
    function automatic int cyc_of(input int limit_ps, input int period_ps);
        int n;
        n = (limit_ps + period_ps - 1) / period_ps;
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
// Down-counter that measures a phase length in clock cycles.
// Assumes load values fit in CW bits; reports zero when the phase is over.
module sram_cycle_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          cnt_zero
);
    logic [CW-1:0] cnt_q;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: walks read and write phases and programs the phase timer.
// Assumes the timer counts N-1 down to 0 for an N-cycle phase.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ACC_CYC  = 3,
    parameter int TURN_CYC = 2,
    parameter int WP_CYC   = 2,
    parameter int CW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          timer_zero,
    output seq_state_e    state_q,
    output seq_state_e    state_d,
    output logic          timer_load,
    output logic [CW-1:0] timer_val,
    output logic          accept,
    output logic          capture
);
    localparam logic [CW-1:0] ACC_LD  = CW'(ACC_CYC - 1);
    localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);
    localparam logic [CW-1:0] WP_LD   = CW'(WP_CYC - 1);

    // Next-phase selection and timer programming.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept     = 1'b1;
                    timer_load = 1'b1;
                    if (req_write) begin
                        state_d   = ST_WR_TURN;
                        timer_val = TURN_LD;
                    end else begin
                        state_d   = ST_RD_ACC;
                        timer_val = ACC_LD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (timer_zero) begin
                    state_d = ST_RD_ACK;
                    capture = 1'b1;
                end
            end
            ST_RD_ACK:  state_d = ST_IDLE;
            ST_WR_TURN: begin
                if (timer_zero) begin
                    state_d    = ST_WR_PULSE;
                    timer_load = 1'b1;
                    timer_val  = WP_LD;
                end
            end
            ST_WR_PULSE: begin
                if (timer_zero) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/sram_strobe_gen.sv
// Registered strobe decoder: turns the next phase into glitch-free pin levels.
// Assumes strobes take effect in the same cycle the phase register does.
module sram_strobe_gen
    import sram_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_d,
    output strobe_t    strobe_q
);
    strobe_t strobe_d;

    // Pin levels for each phase.
    always_comb begin
        strobe_d = STROBE_IDLE;
        case (state_d)
            ST_RD_ACC:   begin strobe_d.ce_n = 1'b0; strobe_d.oe_n = 1'b0; end
            ST_RD_ACK:   begin strobe_d.ce_n = 1'b0; strobe_d.rsp  = 1'b1; end
            ST_WR_TURN:  begin strobe_d.ce_n = 1'b0; end
            ST_WR_PULSE: begin strobe_d.ce_n = 1'b0; strobe_d.we_n = 1'b0; strobe_d.drive = 1'b1; end
            ST_WR_HOLD:  begin strobe_d.ce_n = 1'b0; strobe_d.drive = 1'b1; end
            default:     strobe_d = STROBE_IDLE;
        endcase
    end

    // Strobe register, standby levels in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= STROBE_IDLE;
        else        strobe_q <= strobe_d;
    end
endmodule

// File: rtl/sram_ctrl.sv
// Top of the asynchronous SRAM access sequencer. Converts picosecond limits
// to cycle counts, latches request fields, and drives the RAM pins.
// Assumes one outstanding request at a time and a separate in/out data bus
// whose enable controls an external tristate buffer.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW        = 15,
    parameter int DW        = 8,
    parameter int T_CLK_PS  = 5000,
    parameter int T_AA_PS   = 12000,
    parameter int T_OE_PS   = 7000,
    parameter int T_RC_PS   = 12000,
    parameter int T_WP_PS   = 8000,
    parameter int T_DW_PS   = 8000,
    parameter int T_OHZ_PS  = 6000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int ACC_CYC  = imax(imax(cyc_of(T_AA_PS, T_CLK_PS), cyc_of(T_OE_PS, T_CLK_PS)),
                                   cyc_of(T_RC_PS, T_CLK_PS));
    localparam int TURN_CYC = cyc_of(T_OHZ_PS, T_CLK_PS);
    localparam int WP_CYC   = imax(cyc_of(T_WP_PS, T_CLK_PS), cyc_of(T_DW_PS, T_CLK_PS));
    localparam int MAX_CYC  = imax(imax(ACC_CYC, TURN_CYC), WP_CYC);
    localparam int CW       = $clog2(MAX_CYC + 1);

    seq_state_e    state_q, state_d;
    logic          timer_load, timer_zero, accept, capture;
    logic [CW-1:0] timer_val;
    strobe_t       strobe_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;

    sram_seq_fsm #(.ACC_CYC(ACC_CYC), .TURN_CYC(TURN_CYC), .WP_CYC(WP_CYC), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .timer_zero(timer_zero), .state_q(state_q), .state_d(state_d),
        .timer_load(timer_load), .timer_val(timer_val), .accept(accept), .capture(capture)
    );

    sram_cycle_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val), .cnt_zero(timer_zero)
    );

    sram_strobe_gen u_strobe (
        .clk(clk), .rst_n(rst_n), .state_d(state_d), .strobe_q(strobe_q)
    );

    // Request fields held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Read byte sampled on the last access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= mem_dq_in;
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign rsp_valid  = strobe_q.rsp;
    assign rsp_rdata  = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_ce_n   = strobe_q.ce_n;
    assign mem_oe_n   = strobe_q.oe_n;
    assign mem_we_n   = strobe_q.we_n;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = strobe_q.drive;
endmodule

// File: rtl/sram_ctrl_chk.sv
// Protocol checker for the SRAM access sequencer, attached by bind.
// Assumes the pin-level view only; window lengths are tracked with counters.
module sram_ctrl_chk #(
    parameter int AW       = 15,
    parameter int DW       = 8,
    parameter int TURN_CYC = 2,
    parameter int WP_CYC   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic [DW-1:0] mem_dq_out,
    input logic          mem_dq_oe
);
    logic [7:0] we_lo_cnt, oe_hi_cnt;

    // Length of the current write-strobe low run.
    always_ff @(posedge clk) begin
        if (!rst_n)           we_lo_cnt <= '0;
        else if (mem_we_n)    we_lo_cnt <= '0;
        else if (we_lo_cnt != 8'hFF) we_lo_cnt <= we_lo_cnt + 1'b1;
    end

    // Cycles since output-enable last went high.
    always_ff @(posedge clk) begin
        if (!rst_n)           oe_hi_cnt <= '0;
        else if (!mem_oe_n)   oe_hi_cnt <= '0;
        else if (oe_hi_cnt != 8'hFF) oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end

    AST_NO_BUS_FIGHT:  assert property (@(posedge clk) disable iff (!rst_n) !(mem_dq_oe && !mem_oe_n)); // R7
    AST_WE_OE_APART:   assert property (@(posedge clk) disable iff (!rst_n) !(!mem_we_n && !mem_oe_n)); // R7
    AST_WE_UNDER_CE:   assert property (@(posedge clk) disable iff (!rst_n) !mem_we_n |-> !mem_ce_n); // R5
    AST_IDLE_STANDBY:  assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (mem_ce_n && !mem_dq_oe)); // R9
    AST_RSP_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R3
    AST_ADDR_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R8
    AST_DATA_HELD:     assert property (@(posedge clk) disable iff (!rst_n) (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R6
    AST_WE_PULSE_MIN:  assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> (we_lo_cnt >= 8'(WP_CYC))); // R10
    AST_TURN_WAIT:     assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_dq_oe) |-> (oe_hi_cnt >= 8'(TURN_CYC))); // R10
    AST_DRIVE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_we_n) |-> mem_dq_oe); // R6
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .DW(DW), .TURN_CYC(TURN_CYC), .WP_CYC(WP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    localparam int PER_PS = 5000;
    localparam int ACC  = (12000 + PER_PS - 1) / PER_PS;
    localparam int TURN = (6000 + PER_PS - 1) / PER_PS;
    localparam int WP   = (8000 + PER_PS - 1) / PER_PS;
    localparam int IDLE_TAG = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [14:0] mem_addr;

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 1'b0;

    always #2.5ns clk = ~clk;

    sram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // RAM model: reads drive the bus when selected and enabled, writes land as the strobe rises.
    logic [7:0] sram [int];
    logic we_prev = 1'b1;
    function automatic logic [7:0] sram_rd(input int a);
        return sram.exists(a) ? sram[a] : 8'h00;
    endfunction
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? sram_rd(int'(mem_addr)) : 8'hEE;
    always @(negedge clk) begin
        if (!we_prev && mem_we_n && !mem_ce_n && mem_dq_oe) sram[int'(mem_addr)] = mem_dq_out;
        we_prev = mem_we_n;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Reference model: expected pin pattern per cycle, {ce_n,oe_n,we_n,drive,rsp}.
    logic [4:0]  eq_pin [$];
    logic [14:0] eq_adr [$];
    logic [7:0]  eq_dat [$];
    int          eq_tag [$];
    logic [7:0]  ref_mem [int];

    function automatic string tname(input int t);
        case (t)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic push(input logic [4:0] p, input logic [14:0] a, input logic [7:0] d, input int t);
        eq_pin.push_back(p); eq_adr.push_back(a); eq_dat.push_back(d); eq_tag.push_back(t);
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [4:0] ep, gp;
            logic [14:0] ea;
            logic [7:0] ed;
            int t;
            cyc++;
            if (eq_pin.size() > 0) begin
                ep = eq_pin.pop_front(); ea = eq_adr.pop_front();
                ed = eq_dat.pop_front(); t = eq_tag.pop_front();
            end else begin
                ep = 5'b11100; ea = '0; ed = '0; t = IDLE_TAG;
            end
            gp = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid};
            chk(gp == ep, tname(t), 32'(gp), 32'(ep));
            chk(req_ready == (t == IDLE_TAG), "R8 ready", 32'(req_ready), 32'(t == IDLE_TAG));
            if (t != IDLE_TAG) chk(mem_addr == ea, tname(t), 32'(mem_addr), 32'(ea));
            if (ep[1]) chk(mem_dq_out == ed, "R5 data", 32'(mem_dq_out), 32'(ed));
            if (ep[0]) chk(rsp_rdata == ed, "R3 rdata", 32'(rsp_rdata), 32'(ed));
            chk(!(mem_dq_oe && !mem_oe_n) && !(!mem_we_n && !mem_oe_n), "R7",
                32'(gp), 32'(ep));
            if (req_valid && req_ready) begin
                if (req_write) begin
                    ref_mem[int'(req_addr)] = req_wdata;
                    for (int i = 0; i < TURN; i++) push(5'b01100, req_addr, req_wdata, 4);
                    for (int i = 0; i < WP; i++)   push(5'b01010, req_addr, req_wdata, 5);
                    push(5'b01110, req_addr, req_wdata, 6);
                end else begin
                    logic [7:0] rv;
                    rv = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
                    for (int i = 0; i < ACC; i++) push(5'b00100, req_addr, rv, 2);
                    push(5'b01101, req_addr, rv, 3);
                end
            end
        end
    end

    // Present one request and hold it until the block takes it.
    task automatic do_req(input bit w, input logic [14:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (ACC + TURN + WP + 4) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid} == 5'b11100, "R1 pins",
            32'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}), 32'h1C);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
        @(posedge clk); #1; rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R5 R6: writes at the address extremes
        do_req(1'b1, 15'h0000, 8'h5A);
        do_req(1'b1, 15'h7FFF, 8'hA5);
        // R2 R3: reads back, write-to-read switch (R9)
        do_req(1'b0, 15'h7FFF, 8'h00);
        do_req(1'b0, 15'h0000, 8'h00);
        do_req(1'b0, 15'h1234, 8'h00);
        // R9: alternating direction back to back
        do_req(1'b1, 15'h2AAA, 8'h3C);
        do_req(1'b0, 15'h2AAA, 8'h00);
        do_req(1'b1, 15'h5555, 8'hC3);
        do_req(1'b1, 15'h5556, 8'h81);
        do_req(1'b0, 15'h5556, 8'h00);
        do_req(1'b0, 15'h5555, 8'h00);
        settle();
        // R8: fields change while busy; pins must keep the accepted access
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h2AAA;
        @(posedge clk); #1;
        req_write = 1'b1; req_addr = 15'h0F0F; req_wdata = 8'hFF;
        @(negedge clk);
        chk(mem_addr == 15'h2AAA, "R8 addr", 32'(mem_addr), 32'h2AAA);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk(mem_addr == 15'h2AAA && mem_we_n, "R8 hold", 32'(mem_addr), 32'h2AAA);
        settle();
        do_req(1'b0, 15'h0F0F, 8'h00);
        settle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog cycle=%0d actual=hung expected=done", cyc);
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule